// File: doc/BRIEF.md
# Prescaled Timer with Capture/Compare Channels

A free-running up-counter peripheral that several software tasks can share for time-keeping. A power-of-two prescaler divides the input clock: an exponent N makes the count advance once every 2^N clocks, so N = 4 turns a 16 MHz clock into a 1 us tick. The counter width can be 8, 16, 24 or 32 bits and wraps to zero after all-ones. Software cannot load the count. It can only clear it to zero, and it reads the count by asking a channel to capture it.

Software controls the block through write-one command bits on a single-cycle synchronous register port. One command word starts, stops or clears the counter, or captures the live count into any of the four channel registers. Each channel register also serves as a compare value. When the counter steps onto that value, the channel's event flag is set and stays set until software writes a 0 to it. Interrupt enables are set and cleared through two separate write-one registers. The interrupt line is high while any flag is set whose enable is also set.

Register word addresses (4-bit): 0 command/status, 1 configuration, 2 enable-set, 3 enable-clear, 4+i event flag of channel i, 8+i compare/capture register of channel i. Read data is registered: it reflects the address presented in the previous cycle and the state before that edge.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter is stopped and 0, every register reads 0, all flags and enables are clear, and irq is low.
- R2: While running with prescaler exponent N (configuration bits [3:0]), the count advances once every 2^N clocks. The first step comes 2^N clocks after the start edge.
- R3: Configuration bits [5:4] select the counter width as 8*(code+1) bits. The count wraps from all-ones of that width to 0, and compares use only the low bits of that width.
- R4: Command bit 0 starts counting and command bit 1 stops it, with stop taking priority. While stopped the count holds. Command/status bit 0 reads 1 while running.
- R5: Command bit 2 zeroes the counter and the prescaler whether running or stopped, and it wins over a step in the same cycle.
- R6: Command bit 4+i copies the count (its value before that edge) into channel i's register.
- R7: A channel's flag is set only on a step that brings the counter onto its register value. It is never set while stopped or by a clear.
- R8: Writing 0 in bit 0 of a channel's event address clears its flag. Writing 1 leaves it unchanged, and a hit in the same cycle wins.
- R9: A 1 in bit i of the enable-set register enables channel i, and a 1 in the enable-clear register disables it. Zero bits leave enables unchanged, and both addresses read the enable vector.
- R10: irq is high exactly while some channel has both its flag and its enable set.
- R11: Channel registers and the configuration register can be written and read back through the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous address |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is driven at two prescaler exponents (2 and 4) with 32-bit width, and at exponent 0 with 8-bit width across a wrap. Periodic captures show whether the divide ratio, the start latency and the wrap point are right. A compare value is placed ahead of a running counter to show that a flag is raised on a step onto the value. A capture taken while stopped makes the register equal the held count, which shows that equality alone, without a step, raises nothing. Clears are issued both running and stopped, and the flag and enable writes with 0 and 1 bits show which bits act and which are ignored. The reference model is compared with read data and irq on every clock.

// File: rtl/cct_pkg.sv
package cct_pkg;
   localparam int ADDR_W  = 4;
   localparam int EXP_W   = 4;
   localparam int WCODE_W = 2;
   localparam int MAX_CH  = 4;

   localparam logic [ADDR_W-1:0] A_CMD   = 4'h0;
   localparam logic [ADDR_W-1:0] A_CFG   = 4'h1;
   localparam logic [ADDR_W-1:0] A_ENSET = 4'h2;
   localparam logic [ADDR_W-1:0] A_ENCLR = 4'h3;
   localparam logic [ADDR_W-1:0] A_EVT0  = 4'h4;
   localparam logic [ADDR_W-1:0] A_CC0   = 4'h8;

   localparam int B_START = 0;
   localparam int B_STOP  = 1;
   localparam int B_CLEAR = 2;
   localparam int B_CAP0  = 4;

   typedef struct packed {
      logic [WCODE_W-1:0] wcode;
      logic [EXP_W-1:0]   expo;
   } cfg_t;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
   parameter  int EXP_W = 4,
   localparam int PRE_W = (1 << EXP_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [EXP_W-1:0] expo,
   output logic             tick
);
   logic [PRE_W-1:0] pre;
   logic [PRE_W-1:0] low_mask;

   always_comb low_mask = ~({PRE_W{1'b1}} << expo);
   always_comb tick = run && ((pre & low_mask) == low_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre <= '0;
      else if (restart) pre <= '0;
      else              pre <= pre + 1'b1;
   end

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && expo != '0 && !restart) |=> (!tick || expo != $past(expo)));
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
   parameter int CNT_W     = 32,
   parameter int WCODE_W   = 2,
   parameter bit WIDTH_SEL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               clr,
   input  logic [WCODE_W-1:0] wcode,
   output logic [CNT_W-1:0]   cnt,
   output logic [CNT_W-1:0]   cnt_inc,
   output logic [CNT_W-1:0]   wmask,
   output logic               adv
);
   generate
      if (WIDTH_SEL) begin : g_sel
         always_comb begin
            wmask = '0;
            for (int b = 0; b < CNT_W; b++)
               if (b < 8 * (int'(wcode) + 1)) wmask[b] = 1'b1;
         end
      end else begin : g_fixed
         assign wmask = '1;
      end
   endgenerate

   always_comb adv     = tick && !clr;
   always_comb cnt_inc = (cnt + 1'b1) & wmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt_inc;
   end

   // R5
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(cnt));
   // R3
   width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> ((cnt & ~$past(wmask)) == '0));
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic [CNT_W-1:0] wmask,
   input  logic             cap,
   input  logic             cc_we,
   input  logic [CNT_W-1:0] cc_wdata,
   input  logic             flag_clr,
   input  logic             en_set,
   input  logic             en_clr,
   output logic [CNT_W-1:0] cc,
   output logic             flag,
   output logic             en,
   output logic             req
);
   logic hit;

   always_comb hit = adv && (cnt_inc == (cc & wmask));
   always_comb req = flag && en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cc <= '0;
      else if (cap)   cc <= cnt;
      else if (cc_we) cc <= cc_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (hit)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= 1'b0;
      else if (en_set) en <= 1'b1;
      else if (en_clr) en <= 1'b0;
   end

   // R6
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (cc == $past(cnt)));
   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
   // R7
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !flag) |=> !flag);
   // R9
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_set |=> en);
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
   parameter int CNT_W     = 32,
   parameter int NCH       = 4,
   parameter bit WIDTH_SEL = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_we,
   input  logic [cct_pkg::ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]          bus_wdata,
   output logic [CNT_W-1:0]          bus_rdata,
   output logic                      irq
);
   import cct_pkg::*;

   initial begin
      cnt_width_ok: assert (CNT_W >= 8 && CNT_W <= 32 && CNT_W % 8 == 0)
         else $error("CNT_W must be 8, 16, 24 or 32");
      ch_count_ok: assert (NCH >= 1 && NCH <= MAX_CH)
         else $error("NCH out of range");
   end

   logic                      wr_cmd, start_stb, stop_stb, clear_stb;
   logic                      running, tick, adv;
   cfg_t                      cfg;
   logic [CNT_W-1:0]          cnt, cnt_inc, wmask, rd_mux;
   logic [NCH-1:0]            cap, cc_we, flag_clr, en_set, en_clr;
   logic [NCH-1:0]            flags, ens, reqs;
   logic [NCH-1:0][CNT_W-1:0] cc;

   always_comb begin
      wr_cmd    = bus_we && bus_addr == A_CMD;
      start_stb = wr_cmd && bus_wdata[B_START];
      stop_stb  = wr_cmd && bus_wdata[B_STOP];
      clear_stb = wr_cmd && bus_wdata[B_CLEAR];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         running <= 1'b0;
      else if (stop_stb)  running <= 1'b0;
      else if (start_stb) running <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg <= '0;
      else if (bus_we && bus_addr == A_CFG)
         cfg <= cfg_t'(bus_wdata[EXP_W+WCODE_W-1:0]);
   end

   cct_prescaler #(.EXP_W(EXP_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (running && !stop_stb),
      .restart (clear_stb || !running),
      .expo    (cfg.expo),
      .tick    (tick)
   );

   cct_counter #(.CNT_W(CNT_W), .WCODE_W(WCODE_W), .WIDTH_SEL(WIDTH_SEL)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .clr     (clear_stb),
      .wcode   (cfg.wcode),
      .cnt     (cnt),
      .cnt_inc (cnt_inc),
      .wmask   (wmask),
      .adv     (adv)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         always_comb begin
            cap[i]      = wr_cmd && bus_wdata[B_CAP0+i];
            cc_we[i]    = bus_we && bus_addr == A_CC0 + ADDR_W'(i);
            flag_clr[i] = bus_we && bus_addr == A_EVT0 + ADDR_W'(i) && !bus_wdata[0];
            en_set[i]   = bus_we && bus_addr == A_ENSET && bus_wdata[i];
            en_clr[i]   = bus_we && bus_addr == A_ENCLR && bus_wdata[i];
         end

         cct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (adv),
            .cnt      (cnt),
            .cnt_inc  (cnt_inc),
            .wmask    (wmask),
            .cap      (cap[i]),
            .cc_we    (cc_we[i]),
            .cc_wdata (bus_wdata),
            .flag_clr (flag_clr[i]),
            .en_set   (en_set[i]),
            .en_clr   (en_clr[i]),
            .cc       (cc[i]),
            .flag     (flags[i]),
            .en       (ens[i]),
            .req      (reqs[i])
         );
      end
   endgenerate

   always_comb irq = |reqs;

   always_comb begin
      rd_mux = '0;
      if (bus_addr == A_CMD) rd_mux = CNT_W'(running);
      if (bus_addr == A_CFG) rd_mux = CNT_W'(cfg);
      if (bus_addr == A_ENSET || bus_addr == A_ENCLR) rd_mux = CNT_W'(ens);
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == A_EVT0 + ADDR_W'(i)) rd_mux = CNT_W'(flags[i]);
         if (bus_addr == A_CC0 + ADDR_W'(i))  rd_mux = cc[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_mux;
   end

   // R4
   stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb |=> !running);
   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ens == '0) |-> !irq);
endmodule

// File: tb/cc_timer_test.sv
module cc_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        irq;

   int    checks = 0;
   int    fails = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   cc_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference model
   logic [31:0] m_cnt;
   int          m_pre;
   bit          m_run;
   logic [3:0]  m_exp;
   logic [1:0]  m_wc;
   logic [31:0] m_cc [4];
   bit          m_flag [4];
   bit          m_en [4];
   logic [31:0] exp_rd;
   bit          exp_irq;
   bit          t_cmd, t_start, t_stop, t_clr, t_tick;
   bit          t_hit [4];
   logic [31:0] t_wm, t_next;

   function automatic logic [31:0] mread(input logic [3:0] a);
      logic [31:0] v = 32'h0;
      if (a == 4'h0) v = {31'h0, m_run};
      else if (a == 4'h1) v = {26'h0, m_wc, m_exp};
      else if (a == 4'h2 || a == 4'h3) v = {28'h0, m_en[3], m_en[2], m_en[1], m_en[0]};
      else if (a >= 4'h4 && a <= 4'h7) v = {31'h0, m_flag[a - 4'h4]};
      else if (a >= 4'h8 && a <= 4'hb) v = m_cc[a - 4'h8];
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_run = 0; m_exp = 0; m_wc = 0;
         exp_rd = 0; exp_irq = 0;
         for (int i = 0; i < 4; i++) begin m_cc[i] = 0; m_flag[i] = 0; m_en[i] = 0; end
      end else begin
         exp_rd  = mread(bus_addr);
         t_cmd   = bus_we && bus_addr == 4'h0;
         t_start = t_cmd && bus_wdata[0];
         t_stop  = t_cmd && bus_wdata[1];
         t_clr   = t_cmd && bus_wdata[2];
         t_wm    = (m_wc == 2'd3) ? 32'hffff_ffff : ((32'h1 << (8 * (m_wc + 1))) - 1);
         t_tick  = m_run && !t_stop && (m_pre == (1 << m_exp) - 1);
         t_next  = (m_cnt + 1) & t_wm;
         for (int i = 0; i < 4; i++)
            t_hit[i] = t_tick && !t_clr && (t_next == (m_cc[i] & t_wm));
         for (int i = 0; i < 4; i++) begin
            if (t_cmd && bus_wdata[4+i]) m_cc[i] = m_cnt;
            else if (bus_we && bus_addr == 4'h8 + 4'(i)) m_cc[i] = bus_wdata;
            if (t_hit[i]) m_flag[i] = 1;
            else if (bus_we && bus_addr == 4'h4 + 4'(i) && !bus_wdata[0]) m_flag[i] = 0;
            if (bus_we && bus_addr == 4'h2 && bus_wdata[i]) m_en[i] = 1;
            else if (bus_we && bus_addr == 4'h3 && bus_wdata[i]) m_en[i] = 0;
         end
         if (!m_run || t_clr) m_pre = 0;
         else if (m_pre == (1 << m_exp) - 1) m_pre = 0;
         else m_pre = m_pre + 1;
         if (t_clr) m_cnt = 0;
         else if (t_tick) m_cnt = t_next;
         if (t_stop) m_run = 0;
         else if (t_start) m_run = 1;
         if (bus_we && bus_addr == 4'h1) begin
            m_exp = bus_wdata[3:0];
            m_wc  = bus_wdata[5:4];
         end
         exp_irq = 0;
         for (int i = 0; i < 4; i++) if (m_flag[i] && m_en[i]) exp_irq = 1;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks = checks + 2;
         if (bus_rdata !== exp_rd) begin
            fails++;
            $display("FAIL %s: rdata actual %h expected %h", cur_req, bus_rdata, exp_rd);
         end
         if (irq !== exp_irq) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b", cur_req, irq, exp_irq);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = 32'h0;
   endtask

   task automatic watch(input logic [3:0] a, input int n);
      bus_addr = a;
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of every address
      cur_req = "R1";
      for (int a = 0; a < 12; a++) watch(4'(a), 2);
      // R11: config and channel register readback
      cur_req = "R11";
      wr(4'h1, 32'h0000_0032);   // width code 3, exponent 2
      watch(4'h1, 2);
      wr(4'h8, 32'h0000_0005);
      wr(4'hb, 32'hdead_beef);
      watch(4'h8, 2); watch(4'hb, 2);
      wr(4'hb, 32'h0);
      // R9: set/clear enables, zero bits ignored
      cur_req = "R9";
      wr(4'h2, 32'h0000_0003);
      watch(4'h2, 2);
      wr(4'h3, 32'h0000_0000);
      watch(4'h3, 2);
      wr(4'h3, 32'h0000_0002);
      watch(4'h2, 2);
      // R2 / R7 / R10: run at exponent 2, channel 0 compare at 5
      cur_req = "R2";
      wr(4'h0, 32'h1);
      watch(4'h0, 6);
      wr(4'h0, 32'h20);          // capture into channel 1
      watch(4'h9, 3);
      cur_req = "R7";
      watch(4'h4, 20);
      cur_req = "R6";
      wr(4'h0, 32'h20);
      watch(4'h9, 3);
      // R8: writing 1 keeps flag, writing 0 clears it
      cur_req = "R8";
      wr(4'h4, 32'h1);
      watch(4'h4, 2);
      wr(4'h4, 32'h0);
      watch(4'h4, 2);
      // R4: stop holds count; equal value while stopped raises nothing
      cur_req = "R4";
      wr(4'h0, 32'h2);
      watch(4'h0, 2);
      wr(4'h0, 32'h40);
      watch(4'ha, 8);
      wr(4'h2, 32'h4);
      wr(4'h0, 32'h40);
      watch(4'ha, 2);
      cur_req = "R7";
      watch(4'h6, 10);
      wr(4'h0, 32'h3);           // start and stop together: stop wins
      watch(4'h0, 4);
      wr(4'h0, 32'h1);
      watch(4'h6, 12);
      // R5: clear while running and while stopped
      cur_req = "R5";
      wr(4'h0, 32'h4);
      wr(4'h0, 32'h20);
      watch(4'h9, 3);
      wr(4'h0, 32'h2);
      wr(4'h0, 32'h4);
      wr(4'h0, 32'h20);
      watch(4'h9, 3);
      // R3: 8-bit width, exponent 0, compare at 0x100 matches the wrap
      cur_req = "R3";
      wr(4'h1, 32'h0000_0000);
      wr(4'hb, 32'h0000_0100);
      wr(4'h2, 32'h8);
      wr(4'h0, 32'h1);
      for (int k = 0; k < 6; k++) begin
         watch(4'h7, 50);
         wr(4'h0, 32'h80);
         watch(4'hb, 2);
         wr(4'hb, 32'h0000_0100);
      end
      // R10: disable the flagged channel, flag stays but irq drops
      cur_req = "R10";
      wr(4'h3, 32'hf);
      watch(4'h7, 3);
      wr(4'h2, 32'h8);
      watch(4'h7, 3);
      wr(4'h7, 32'h0);
      watch(4'h3, 3);
      // R2: exponent 4, 32-bit
      cur_req = "R2";
      wr(4'h0, 32'h6);
      wr(4'h1, 32'h0000_0034);
      wr(4'h0, 32'h1);
      for (int k = 0; k < 5; k++) begin
         watch(4'h1, 23);
         wr(4'h0, 32'h10);
         watch(4'h8, 2);
      end
      watch(4'h0, 4);
      finish_run();
   end
endmodule